// File: doc/BRIEF.md
# Threshold Receive FIFO with Final-Byte NACK

This block is a circular receive buffer placed between a byte-wide bus-read engine and a software data register. While a receive is active, it pulls bytes from the bus engine over a valid/ready handshake, at most one per clock. It stops after the number of bytes held reaches a programmable threshold. At that point it raises a sticky threshold status and a full indication. If software has armed a final-transfer flag, the block tells the bus engine to NACK the byte that completed the burst, and the flag then drops by itself.

Software takes bytes out in arrival order with a pop strobe. The popped byte appears on the data output one cycle later. When software pops an empty buffer, the block starts a fresh burst and delivers the first byte of that burst as the popped value. Clearing the threshold status resumes fetching. The data-ready flag follows the threshold when the threshold interrupt is enabled. When that interrupt is disabled, data-ready also signals any byte that is waiting in the buffer.

Top module: `rxq_fifo_top`

## Requirements
- R1: After reset, count_o is 0, rd_data_o is 0, and thst_o, full_o, data_rdy_o, last_armed_o and bus_nack_o are all 0.
- R2: bus_ready_o is high exactly when rx_en_i is high, the threshold is valid, thst_o is low and count_o is below thr_i. Each accepted handshake (bus_valid_i and bus_ready_o) stores one byte and raises count_o by one at the next edge.
- R3: A pop with count_o above zero loads the oldest stored byte into rd_data_o at the next edge and lowers count_o by one. Bytes leave in the order they were accepted, including after the pointers wrap past the last entry.
- R4: The handshake that brings count_o up to thr_i sets thst_o and full_o at the next edge, which makes data_rdy_o high. After that no byte is accepted until thst_o is cleared. thr_i equal to DEPTH is valid.
- R5: A thr_i of 0, or a thr_i larger than DEPTH, drives thr_err_o high and keeps bus_ready_o low, so nothing is stored.
- R6: If last_armed_o is high, bus_nack_o pulses in the cycle in which the threshold-completing byte is accepted, and in no earlier cycle. last_armed_o is 0 from the next edge on.
- R7: A last_arm_i pulse sets last_armed_o. No software input clears it; only the automatic clear of R6 does.
- R8: While thr_ie_i is 0, data_rdy_o is high whenever count_o is non-zero. While thr_ie_i is 1, data_rdy_o is high only while full_o is high. full_o drops on a pop.
- R9: A thst_clr_i pulse clears thst_o. If the receive is still active and count_o is below thr_i, bus_ready_o rises in the following cycle.
- R10: A pop while count_o is 0 clears thst_o and full_o and starts a new burst. The first byte then accepted becomes rd_data_o one edge after it is stored, and count_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | A receive transfer is in progress |
| thr_i | input | CNT_W | Burst threshold in bytes; valid range 1..DEPTH |
| thr_ie_i | input | 1 | Threshold interrupt enable; selects the data-ready rule |
| last_arm_i | input | 1 | Pulse that arms the final-transfer NACK flag |
| thst_clr_i | input | 1 | Pulse that clears the threshold status |
| bus_valid_i | input | 1 | Bus engine offers a byte |
| bus_data_i | input | DW | Byte offered by the bus engine |
| bus_ready_o | output | 1 | Block accepts the offered byte this cycle |
| bus_nack_o | output | 1 | NACK the byte being accepted (final byte of the burst) |
| pop_i | input | 1 | Software read strobe for the data register |
| rd_data_o | output | DW | Last popped byte |
| count_o | output | CNT_W | Number of bytes held |
| thst_o | output | 1 | Threshold reached (sticky) |
| full_o | output | 1 | Burst complete and not yet drained |
| data_rdy_o | output | 1 | Data-ready flag for software |
| thr_err_o | output | 1 | Threshold value out of range |
| last_armed_o | output | 1 | Final-transfer NACK flag |

## Verification
The hardest situation to reach is a pop of an empty buffer after a completed burst. The sticky threshold status must be set, every byte must already be drained, and the bus engine must still be willing to supply data. The stimulus reaches it by completing a two-byte burst, popping both bytes, and then popping once more. The bench then checks that fetching restarts and that the byte supplied afterwards is the one delivered. A closing burst at the full depth starts from a read pointer near the top of the ring, so both pointers wrap while the ordering is checked.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Position in a ring of 'depth' entries, 'step' places after 'base'.
  function automatic int ring_index(input int base, input int step, input int depth);
    return (base + step) % depth;
  endfunction

  // A usable threshold lies between one byte and the full ring.
  function automatic bit thr_in_range(input int thr, input int depth);
    return (thr >= 1) && (thr <= depth);
  endfunction

  // Occupancy after one cycle with an optional push and an optional pop.
  function automatic int count_after(input int cnt, input bit push, input bit take);
    return cnt + (push ? 1 : 0) - (take ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  // One register per ring slot, each written only when addressed.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we_i && (waddr_i == PTR_W'(gi))) begin
        mem[gi] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             do_pop_o,
  output logic             pop_empty_o
);

  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             pend_q;

  // A pop of an empty ring is remembered and served by the first refill byte.
  assign do_pop_o    = (pop_i || pend_q) && (count_q != '0);
  assign pop_empty_o = pop_i && (count_q == '0);

  assign cnt_nxt_o = CNT_W'(rxq_pkg::count_after(int'(count_q), accept_i, do_pop_o));
  assign wr_ptr_o  = PTR_W'(rxq_pkg::ring_index(int'(rd_ptr_q), int'(count_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      count_q  <= '0;
      pend_q   <= 1'b0;
    end else begin
      count_q <= cnt_nxt_o;
      if (do_pop_o) begin
        rd_ptr_q <= PTR_W'(rxq_pkg::ring_index(int'(rd_ptr_q), 1, DEPTH));
      end
      if (pop_empty_o) begin
        pend_q <= 1'b1;
      end else if (do_pop_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             thr_ie_i,
  input  logic             last_arm_i,
  input  logic             thst_clr_i,
  input  logic             accept_i,
  input  logic             do_pop_i,
  input  logic             pop_empty_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             fetch_en_o,
  output logic             reach_o,
  output logic             nack_o,
  output logic             thst_o,
  output logic             full_o,
  output logic             data_rdy_o,
  output logic             thr_err_o,
  output logic             last_o
);

  logic thst_q, full_q, last_q;

  assign thr_err_o  = !rxq_pkg::thr_in_range(int'(thr_i), DEPTH);
  assign fetch_en_o = rx_en_i && !thr_err_o && !thst_q && (count_i < thr_i);
  assign reach_o    = accept_i && (cnt_nxt_i == thr_i);
  assign nack_o     = reach_o && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thst_q <= 1'b0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (reach_o) begin
        thst_q <= 1'b1;
      end else if (thst_clr_i || pop_empty_i) begin
        thst_q <= 1'b0;
      end
      if (reach_o) begin
        full_q <= 1'b1;
      end else if (do_pop_i || thst_clr_i || pop_empty_i) begin
        full_q <= 1'b0;
      end
      // Only the automatic clear removes the flag; arming wins a tie.
      last_q <= last_arm_i || (last_q && !nack_o);
    end
  end

  assign thst_o     = thst_q;
  assign full_o     = full_q;
  assign last_o     = last_q;
  assign data_rdy_o = full_q || (!thr_ie_i && (count_i != '0));

endmodule

// File: rtl/rxq_fifo_top.sv
module rxq_fifo_top #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             thr_ie_i,
  input  logic             last_arm_i,
  input  logic             thst_clr_i,
  input  logic             bus_valid_i,
  input  logic [DW-1:0]    bus_data_i,
  output logic             bus_ready_o,
  output logic             bus_nack_o,
  input  logic             pop_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             thst_o,
  output logic             full_o,
  output logic             data_rdy_o,
  output logic             thr_err_o,
  output logic             last_armed_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, visible to the bound checker.
  logic             accept;
  logic             do_pop;
  logic             pop_empty;
  logic             reach;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] cnt_nxt;
  logic [DW-1:0]    head_byte;
  logic [DW-1:0]    rd_data_q;

  assign accept = bus_valid_i && bus_ready_o;

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .pop_i      (pop_i),
    .rd_ptr_o   (rd_ptr),
    .wr_ptr_o   (wr_ptr),
    .count_o    (count_o),
    .cnt_nxt_o  (cnt_nxt),
    .do_pop_o   (do_pop),
    .pop_empty_o(pop_empty)
  );

  rxq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en_i    (rx_en_i),
    .thr_i      (thr_i),
    .thr_ie_i   (thr_ie_i),
    .last_arm_i (last_arm_i),
    .thst_clr_i (thst_clr_i),
    .accept_i   (accept),
    .do_pop_i   (do_pop),
    .pop_empty_i(pop_empty),
    .count_i    (count_o),
    .cnt_nxt_i  (cnt_nxt),
    .fetch_en_o (bus_ready_o),
    .reach_o    (reach),
    .nack_o     (bus_nack_o),
    .thst_o     (thst_o),
    .full_o     (full_o),
    .data_rdy_o (data_rdy_o),
    .thr_err_o  (thr_err_o),
    .last_o     (last_armed_o)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .PTR_W(PTR_W)) u_store (
    .clk    (clk),
    .we_i   (accept),
    .waddr_i(wr_ptr),
    .wdata_i(bus_data_i),
    .raddr_i(rd_ptr),
    .rdata_o(head_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (do_pop) begin
      rd_data_q <= head_byte;
    end
  end

  assign rd_data_o = rd_data_q;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en_i,
  input logic [CNT_W-1:0] thr_i,
  input logic             thr_ie_i,
  input logic             last_arm_i,
  input logic             accept,
  input logic             bus_ready_o,
  input logic             bus_nack_o,
  input logic [CNT_W-1:0] count_o,
  input logic             thst_o,
  input logic             full_o,
  input logic             data_rdy_o,
  input logic             thr_err_o,
  input logic             last_armed_o
);

  assert_ready_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready_o |-> (rx_en_i && !thst_o && (count_o < thr_i)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1))
              || (count_o + CNT_W'(1) == $past(count_o))));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  assert_thr_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thst_o) |-> (full_o && data_rdy_o && !bus_ready_o));

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_err_o |-> !bus_ready_o);

  assert_nack_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nack_o |-> (last_armed_o && accept && (count_o + CNT_W'(1) == thr_i)));

  assert_last_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_nack_o && !last_arm_i) |=> !last_armed_o);

  assert_last_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_armed_o && !bus_nack_o) |=> last_armed_o);

  assert_rdy_no_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_ie_i && (count_o != '0)) |-> data_rdy_o);

endmodule

bind rxq_fifo_top rxq_chk #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en_i     (rx_en_i),
  .thr_i       (thr_i),
  .thr_ie_i    (thr_ie_i),
  .last_arm_i  (last_arm_i),
  .accept      (accept),
  .bus_ready_o (bus_ready_o),
  .bus_nack_o  (bus_nack_o),
  .count_o     (count_o),
  .thst_o      (thst_o),
  .full_o      (full_o),
  .data_rdy_o  (data_rdy_o),
  .thr_err_o   (thr_err_o),
  .last_armed_o(last_armed_o)
);

// File: tb/tb_rxq_fifo_top.sv
module tb_rxq_fifo_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, thr_ie = 1'b1, last_arm = 1'b0, thst_clr = 1'b0;
  logic [CNT_W-1:0] thr = CNT_W'(4);
  logic bus_valid = 1'b0, pop = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic bus_ready_o, bus_nack_o, thst_o, full_o, data_rdy_o, thr_err_o, last_armed_o;
  logic [7:0] rd_data_o;
  logic [CNT_W-1:0] count_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  event mon_ev;
  bit taken, nk;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_fifo_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .thr_i(thr), .thr_ie_i(thr_ie),
    .last_arm_i(last_arm), .thst_clr_i(thst_clr), .bus_valid_i(bus_valid),
    .bus_data_i(bus_data), .bus_ready_o(bus_ready_o), .bus_nack_o(bus_nack_o),
    .pop_i(pop), .rd_data_o(rd_data_o), .count_o(count_o), .thst_o(thst_o),
    .full_o(full_o), .data_rdy_o(data_rdy_o), .thr_err_o(thr_err_o),
    .last_armed_o(last_armed_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: offers one byte for one cycle; a byte seen as accepted is queued.
  task automatic feed(input logic [7:0] b, output bit took, output bit nack_seen);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_data  = b;
    #1;
    took      = bus_ready_o;
    nack_seen = bus_nack_o;
    if (took) exp_q.push_back(b);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // Pop with data present: the byte is on rd_data_o at the following negedge.
  task automatic pop_one();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    -> mon_ev;
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); thst_clr = 1'b1;
    @(negedge clk); thst_clr = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); last_arm = 1'b1;
    @(negedge clk); last_arm = 1'b0;
  endtask

  // Monitor: compares each delivered byte with the oldest accepted one (R3).
  always @(mon_ev) begin
    if (exp_q.size() == 0) begin
      chk("R3 pop with empty scoreboard", 1, 0);
    end else begin
      chk("R3 arrival order", int'(rd_data_o), int'(exp_q.pop_front()));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 thst", int'(thst_o), 0);
    chk("R1 full", int'(full_o), 0);
    chk("R1 data_rdy", int'(data_rdy_o), 0);
    chk("R1 last", int'(last_armed_o), 0);
    chk("R1 rd_data", int'(rd_data_o), 0);
    chk("R1 nack", int'(bus_nack_o), 0);

    // R5 invalid thresholds block filling
    rx_en = 1'b1;
    thr = '0;
    #1;
    chk("R5 thr 0 err", int'(thr_err_o), 1);
    feed(8'hE0, taken, nk);
    chk("R5 thr 0 not taken", int'(taken), 0);
    thr = CNT_W'(DEPTH + 1);
    feed(8'hE1, taken, nk);
    chk("R5 thr over depth err", int'(thr_err_o), 1);
    chk("R5 thr over depth not taken", int'(taken), 0);
    chk("R5 count still 0", int'(count_o), 0);
    thr = CNT_W'(DEPTH);
    #1;
    chk("R4 thr at depth valid", int'(thr_err_o), 0);

    // R2/R4/R8 burst of four with the threshold interrupt enabled
    thr = CNT_W'(4);
    feed(8'h11, taken, nk); chk("R2 byte 1 taken", int'(taken), 1);
    chk("R2 count 1", int'(count_o), 1);
    feed(8'h22, taken, nk);
    feed(8'h33, taken, nk);
    chk("R2 count 3", int'(count_o), 3);
    chk("R8 ie on no data_rdy below thr", int'(data_rdy_o), 0);
    feed(8'h44, taken, nk);
    chk("R4 thst", int'(thst_o), 1);
    chk("R4 full", int'(full_o), 1);
    chk("R4 data_rdy", int'(data_rdy_o), 1);
    chk("R4 ready low", int'(bus_ready_o), 0);
    chk("R4 count 4", int'(count_o), 4);
    feed(8'h55, taken, nk);
    chk("R4 fifth byte refused", int'(taken), 0);

    // R3 pops in order
    pop_one();
    pop_one();
    chk("R3 count after 2 pops", int'(count_o), 2);
    chk("R8 full drops on pop", int'(full_o), 0);
    chk("R8 data_rdy follows full", int'(data_rdy_o), 0);

    // R9 clearing status resumes fetching
    pulse_clr();
    chk("R9 thst cleared", int'(thst_o), 0);
    chk("R9 ready resumes", int'(bus_ready_o), 1);
    feed(8'h66, taken, nk);
    feed(8'h77, taken, nk);
    chk("R9 thst again", int'(thst_o), 1);
    for (int i = 0; i < 4; i++) pop_one();
    chk("R3 drained", int'(count_o), 0);

    // R6 final-byte NACK
    pulse_arm();
    chk("R7 armed", int'(last_armed_o), 1);
    thr = CNT_W'(3);
    pulse_clr();
    feed(8'hA1, taken, nk); chk("R6 no nack byte 1", int'(nk), 0);
    feed(8'hA2, taken, nk); chk("R6 no nack byte 2", int'(nk), 0);
    feed(8'hA3, taken, nk); chk("R6 nack on final byte", int'(nk), 1);
    chk("R6 last cleared", int'(last_armed_o), 0);
    for (int i = 0; i < 3; i++) pop_one();

    // R7 software cannot clear the flag
    pulse_arm();
    pulse_clr();
    chk("R7 survives status clear", int'(last_armed_o), 1);
    repeat (5) @(negedge clk);
    chk("R7 still armed", int'(last_armed_o), 1);

    // R8 interrupt disabled: any held byte raises data_rdy
    thr_ie = 1'b0;
    thr = CNT_W'(5);
    feed(8'hB1, taken, nk);
    chk("R8 ie off data_rdy", int'(data_rdy_o), 1);
    chk("R8 thst low", int'(thst_o), 0);
    pop_one();
    chk("R8 ie off empty", int'(data_rdy_o), 0);

    // R10 pop on empty after a completed burst
    thr_ie = 1'b1;
    thr = CNT_W'(2);
    feed(8'hC1, taken, nk);
    feed(8'hC2, taken, nk); chk("R6 nack second burst", int'(nk), 1);
    chk("R6 last cleared again", int'(last_armed_o), 0);
    pop_one();
    pop_one();
    chk("R10 ready low at thst", int'(bus_ready_o), 0);
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    #1;
    chk("R10 thst cleared", int'(thst_o), 0);
    chk("R10 refill starts", int'(bus_ready_o), 1);
    feed(8'hD1, taken, nk);
    @(negedge clk);
    chk("R10 refill byte delivered", int'(rd_data_o), 8'hD1);
    chk("R10 count back to 0", int'(count_o), 0);
    void'(exp_q.pop_front());
    feed(8'hD2, taken, nk);
    feed(8'hD3, taken, nk);
    chk("R10 burst completes", int'(thst_o), 1);
    pop_one();
    pop_one();

    // R3/R4 full-depth burst across the ring boundary
    thr = CNT_W'(DEPTH);
    pulse_clr();
    for (int i = 0; i < DEPTH; i++) begin
      feed(8'h80 + 8'(i), taken, nk);
      if (nk) chk("R6 no nack when disarmed", 1, 0);
    end
    chk("R4 count at depth", int'(count_o), DEPTH);
    chk("R4 thst at depth", int'(thst_o), 1);
    for (int i = 0; i < DEPTH; i++) pop_one();
    chk("R3 ring drained", int'(count_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule